// File: doc/BRIEF.md
# Per-Lane Sync Loss Timer

This block watches every lane of a multi-lane serial MAC and measures how long each lane has been out of synchronization since the link first came up. Each lane has its own timer. A timer advances only on a symbol-period tick, and only while its lane is out of sync on a link that has finished initialization. If a timer reaches its fixed terminal count, the error status bit of the port that owns the lane is set.

The MAC runs as one wide port that uses all lanes, or as two single-lane ports. In split mode, an expiry on the odd port also raises the even port's error bit. This cross-port flag is a known quirk of the shared status path, and it is kept on purpose. Software clears an error bit by writing a one to it.

The terminal count defaults to 0xFFFFF symbol periods. With an 8 ns tick, for example, that is about 8.39 ms. The count is fixed in hardware. The parameter exists only so that a reduced count can be elaborated.

Top module: `sync_loss_timer`

## Requirements
- R1: After reset, both port error bits (`port_err_o[0]` for the even port, `port_err_o[1]` for the odd port) are 0.
- R2: A lane timer stays at zero while its port's link-initialized flag is low, whatever the sync input and tick do. Once the flag rises, the full timeout must elapse before an error is set.
- R3: A lane timer advances only in clock cycles where `sym_tick_i` is 1. An out-of-sync lane with no ticks never causes an error.
- R4: After exactly TIMEOUT ticks of continuous sync loss on an armed lane, the owning port's error bit is set. After TIMEOUT-1 ticks it is not set.
- R5: When a lane regains sync (`lane_sync_i` bit = 1), its timer returns to zero. Sync-loss periods separated by a resync do not add up.
- R6: The timers are independent. Sync loss on one lane does not advance another lane's timer, and an expiry on any lane of a port sets that port's error bit.
- R7: Each error bit stays set until a 1 is written to the matching `err_clr_i` bit. A clear bit for the other port has no effect. A set in the same cycle wins over a clear.
- R8: In wide mode (`split_i` = 0), all lanes belong to port 0 and are armed by `link_up_i[0]`. `port_err_o[1]` is never set in this mode.
- R9: In split mode (`split_i` = 1), lane 0 belongs to port 0 and lane 1 belongs to port 1. An expiry on lane 1 sets both error bits, while an expiry on lane 0 sets only bit 0. Lanes 2 and above are not monitored in this mode.
- R10: In split mode, each port's lane is armed by that port's own `link_up_i` bit.
- R11: A timer expires only once per sync-loss period. It saturates and does not set the error again until the lane has resynced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_i | input | 1 | 0 = one wide port, 1 = two single-lane ports |
| link_up_i | input | 2 | Link-initialized flag per port (bit 0 even, bit 1 odd) |
| lane_sync_i | input | LANES | Per-lane sync indication, 1 = in sync |
| sym_tick_i | input | 1 | One-cycle symbol-period tick |
| err_clr_i | input | 2 | Write-one-to-clear for each port error bit |
| port_err_o | output | 2 | Registered sticky port error status |

## Verification
The bench stops the tick stream one tick short of the terminal count, then lets it run one tick further. A design with an off-by-one count therefore flags too early or not at all. It feeds ticks while the link is down, then raises the link, to catch a timer that counts before it is armed. It also splits a loss into two halves around a resync, and spreads a loss across two lanes, to catch timers that accumulate or share state. In split mode it checks that an odd-lane expiry raises both bits and an even-lane expiry raises one, that an unmonitored lane stays silent, and that a cleared bit does not return while the saturated timer is still running.

// File: rtl/sync_loss_pkg.sv
package sync_loss_pkg;
  localparam int NUM_PORTS = 2;
  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/sync_loss_lane_timer.sv
module sync_loss_lane_timer #(
  parameter int TIMEOUT = 20'hFFFFF,
  parameter int CW      = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic armed_i,
  input  logic sync_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam logic [CW-1:0] TERM  = CW'(TIMEOUT);
  localparam logic [CW-1:0] LAST  = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !armed_i || sync_i) begin
      cnt_q     <= '0;
      expired_o <= 1'b0;
    end else begin
      expired_o <= 1'b0;
      if (tick_i && cnt_q != TERM) begin
        cnt_q     <= cnt_q + 1'b1;
        expired_o <= (cnt_q == LAST);
      end
    end
  end

  p_bounded_r4: assert property (@(posedge clk) disable iff (rst) cnt_q <= TERM);
  p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    expired_o |=> !expired_o);
  p_tick_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && armed_i && !sync_i) |=> $stable(cnt_q));
  p_unarmed_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !armed_i |=> !expired_o);
endmodule

// File: rtl/sync_loss_port_map.sv
module sync_loss_port_map
  import sync_loss_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                 split_i,
  input  logic [NUM_PORTS-1:0] link_up_i,
  input  logic [LANES-1:0]     lane_exp_i,
  output logic [LANES-1:0]     armed_o,
  output logic [NUM_PORTS-1:0] port_set_o
);
  lane_mode_e mode;
  assign mode = lane_mode_e'(split_i);

  for (genvar l = 0; l < LANES; l++) begin : g_arm
    if (l == 0) begin : g_even
      assign armed_o[l] = link_up_i[0];
    end else if (l == 1) begin : g_odd
      assign armed_o[l] = (mode == MODE_SPLIT) ? link_up_i[1] : link_up_i[0];
    end else begin : g_upper
      assign armed_o[l] = (mode == MODE_WIDE) && link_up_i[0];
    end
  end

  always_comb begin
    if (mode == MODE_SPLIT) begin
      port_set_o[1] = lane_exp_i[1];
      port_set_o[0] = lane_exp_i[0] | lane_exp_i[1];
    end else begin
      port_set_o[1] = 1'b0;
      port_set_o[0] = |lane_exp_i;
    end
  end
endmodule

// File: rtl/sync_loss_err_status.sv
module sync_loss_err_status
  import sync_loss_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] set_i,
  input  logic [NUM_PORTS-1:0] clr_i,
  output logic [NUM_PORTS-1:0] err_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           err_o[p] <= 1'b0;
      else if (set_i[p]) err_o[p] <= 1'b1;
      else if (clr_i[p]) err_o[p] <= 1'b0;
    end

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (err_o[p] && !clr_i[p]) |=> err_o[p]);
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      set_i[p] |=> err_o[p]);
  end
endmodule

// File: rtl/sync_loss_timer.sv
module sync_loss_timer
  import sync_loss_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int TIMEOUT = 20'hFFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             split_i,
  input  logic [1:0]       link_up_i,
  input  logic [LANES-1:0] lane_sync_i,
  input  logic             sym_tick_i,
  input  logic [1:0]       err_clr_i,
  output logic [1:0]       port_err_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [LANES-1:0]     armed;
  logic [LANES-1:0]     lane_exp;
  logic [NUM_PORTS-1:0] port_set;

  sync_loss_port_map #(.LANES(LANES)) u_map (
    .split_i   (split_i),
    .link_up_i (link_up_i),
    .lane_exp_i(lane_exp),
    .armed_o   (armed),
    .port_set_o(port_set)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sync_loss_lane_timer #(.TIMEOUT(TIMEOUT), .CW(CW)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .armed_i  (armed[l]),
      .sync_i   (lane_sync_i[l]),
      .tick_i   (sym_tick_i),
      .expired_o(lane_exp[l])
    );
  end

  sync_loss_err_status u_err (
    .clk  (clk),
    .rst  (rst),
    .set_i(port_set),
    .clr_i(err_clr_i),
    .err_o(port_err_o)
  );

  p_odd_mirror_r9: assert property (@(posedge clk) disable iff (rst)
    (split_i && lane_exp[1]) |=> (port_err_o[0] && port_err_o[1]));
  p_wide_odd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!split_i && !port_err_o[1]) |=> !port_err_o[1]);
endmodule

// File: tb/test_sync_loss_timer.sv
`timescale 1ns/1ps
module test_sync_loss_timer;
  localparam int LANES = 4;
  localparam int T     = 16;

  logic             clk = 1'b0;
  logic             rst;
  logic             split_i;
  logic [1:0]       link_up_i;
  logic [LANES-1:0] lane_sync_i;
  logic             sym_tick_i;
  logic [1:0]       err_clr_i;
  logic [1:0]       port_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sync_loss_timer #(.LANES(LANES), .TIMEOUT(T)) i_sync_loss_timer (.*);

  task automatic chk(input string req, input logic [1:0] exp);
    n_chk++;
    if (port_err_o !== exp) begin
      n_bad++;
      $display("FAIL %s: port_err_o=%b expected %b", req, port_err_o, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sym_tick_i = 1'b1;
    end
    @(negedge clk) sym_tick_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear(input logic [1:0] m);
    @(negedge clk) err_clr_i = m;
    @(negedge clk) err_clr_i = 2'b00;
    @(negedge clk);
  endtask

  task automatic resync_all();
    @(negedge clk) lane_sync_i = '1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset", 2'b00);
  endtask

  task automatic t_unarmed();
    split_i = 1'b0; link_up_i = 2'b00; lane_sync_i = '0;
    ticks(3 * T);
    chk("R2 link down ignores loss", 2'b00);
    @(negedge clk) link_up_i = 2'b01;
    ticks(T - 1);
    chk("R2/R4 one tick short", 2'b00);
    ticks(1);
    chk("R4/R8 expiry wide mode", 2'b01);
    clear(2'b01);
    ticks(2 * T);
    chk("R11 no re-expiry while saturated", 2'b00);
    resync_all();
  endtask

  task automatic t_no_tick();
    @(negedge clk) lane_sync_i = 4'b1011;
    repeat (4 * T) @(negedge clk);
    chk("R3 no tick no advance", 2'b00);
    ticks(T);
    chk("R6 lane 2 sets port 0", 2'b01);
    resync_all();
    clear(2'b01);
  endtask

  task automatic t_resync();
    @(negedge clk) lane_sync_i = 4'b1110;
    ticks(T - 1);
    resync_all();
    @(negedge clk) lane_sync_i = 4'b1110;
    ticks(T - 1);
    chk("R5 resync restarts timer", 2'b00);
    ticks(1);
    chk("R5 full period after resync", 2'b01);
    resync_all();
    clear(2'b01);
  endtask

  task automatic t_independent();
    @(negedge clk) lane_sync_i = 4'b1110;
    ticks(T - 2);
    @(negedge clk) lane_sync_i = 4'b1101;
    ticks(T - 2);
    chk("R6 lanes do not share count", 2'b00);
    resync_all();
  endtask

  task automatic t_clear();
    @(negedge clk) lane_sync_i = 4'b0111;
    ticks(T);
    chk("R7 set", 2'b01);
    clear(2'b10);
    chk("R7 other clear no effect", 2'b01);
    repeat (5) @(negedge clk);
    chk("R7 sticky", 2'b01);
    clear(2'b01);
    chk("R7 write one clears", 2'b00);
    resync_all();
  endtask

  task automatic t_split();
    @(negedge clk) begin split_i = 1'b1; link_up_i = 2'b01; lane_sync_i = 4'b1101; end
    ticks(2 * T);
    chk("R10 odd port not up", 2'b00);
    resync_all();
    @(negedge clk) lane_sync_i = 4'b1110;
    ticks(T);
    chk("R9 even expiry sets port 0 only", 2'b01);
    resync_all();
    clear(2'b01);
    @(negedge clk) begin link_up_i = 2'b11; lane_sync_i = 4'b1101; end
    ticks(T);
    chk("R9 odd expiry sets both", 2'b11);
    resync_all();
    clear(2'b11);
    @(negedge clk) lane_sync_i = 4'b0011;
    ticks(2 * T);
    chk("R9 upper lanes unmonitored", 2'b00);
    resync_all();
  endtask

  initial begin
    rst = 1'b1; split_i = 1'b0; link_up_i = 2'b00; lane_sync_i = '1;
    sym_tick_i = 1'b0; err_clr_i = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_no_tick();
    t_resync();
    t_independent();
    t_clear();
    t_split();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule